// File: doc/BRIEF.md
# Character LCD host bus interface

This block is the processor-facing side of a character dot-matrix display controller. A host drives a register-select line, a read/write line and an enable strobe, and moves bytes over a data bus. The block decodes each enable pulse into one of four operations: an instruction write, a status read, a data write, or a data read. It keeps a write-only instruction path, a data register, an address counter and a busy flag. Data is moved between the data register and one of two internal memories: an 80-byte display memory or a 64-byte glyph-pattern memory.

The data register acts as a staging register. After a data write, its contents go into the selected memory at the address counter, and the counter advances. After a data read, the byte at the next address is fetched into it ready for the following read. Only three instructions are decoded: set display address, set pattern address and bus-width select. The bus works 8 bits wide after reset. It can be switched to a 4-bit mode in which every byte moves as two nibbles on the upper four lines. The enable input is sampled by the block clock, so the host must hold each level for at least one clock.

Top module: `lcd_host_if`

## Requirements
- R1: After reset the bus is 8 bits wide, the address counter is 0, the busy flag is clear and the display memory is the target, so a status read returns 0x00.
- R2: With select low and read high, the bus returns the busy flag on bit 7 and the address counter on bits 6..0. An instruction byte written earlier is never returned.
- R3: With select high and read low, the written byte goes into the data register and into the selected memory at the current address, and the address counter advances by one.
- R4: With select high and read high, the bus returns the data register. When enable falls, the address counter advances and the data register is loaded from the selected memory at the new address.
- R5: The instruction 1aaaaaaa targets the display memory with address aaaaaaa. The instruction 01aaaaaa targets the pattern memory with address aaaaaa. Both load the data register from the newly addressed location.
- R6: The instruction 001dxxxx sets the bus width: d=1 selects 8 bits, d=0 selects 4 bits. In 4-bit mode each byte moves as two enable pulses on db[7:4], high nibble first, and db[3:0] read as 0. The nibble phase restarts on this instruction.
- R7: The address counter wraps from 79 to 0 while the display memory is the target, and from 63 to 0 while the pattern memory is the target.
- R8: An accepted write (an instruction, a data byte, or the completing nibble) sets the busy flag from the next clock for BUSY_CYC clocks.
- R9: A write that arrives while busy is ignored. The address counter, the data register and the memories are unchanged.
- R10: The data output enable is high only while enable and read are both high. At all other times db_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Host enable strobe |
| rs_i | input | 1 | Register select: 0 instruction/status, 1 data |
| rw_i | input | 1 | 1 read, 0 write |
| db_i | input | 8 | Host data bus in |
| db_o | output | 8 | Data bus out (0 when not driven) |
| db_oe_o | output | 1 | Data bus output enable |

## Verification
A write takes effect at the first clock edge that sees enable high. Its results (the address counter, the memory contents, and the busy flag, which holds for BUSY_CYC clocks) can be read back from the following cycle. Read data is a combinational function of registered state, so the bench samples it one time unit after it raises enable. The address advance and the prefetch for the next read happen at the edge that sees enable low, and the bench inserts an idle cycle before the next operation so that this edge has passed. A behavioural model counts edges to know which writes land inside a busy window. The bench also checks the bus output enable two time units after every rising edge.

// File: rtl/lcd_host_pkg.sv
package lcd_host_pkg;
  typedef enum logic {RAM_DISP = 1'b0, RAM_PAT = 1'b1} ram_sel_e;

  typedef struct packed {
    logic       rs;
    logic [7:0] data;
  } host_xfer_t;
endpackage

// File: rtl/lcd_bus_phy.sv
module lcd_bus_phy
  import lcd_host_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       rs_i,
  input  logic       rw_i,
  input  logic [7:0] db_i,
  input  logic       wide_i,
  input  logic       clr_phase_i,
  input  logic       blocked_i,
  input  logic [7:0] rd_byte_i,
  output logic       wr_vld_o,
  output host_xfer_t wr_o,
  output logic       rd_done_o,
  output logic       rd_rs_o,
  output logic [7:0] db_o,
  output logic       db_oe_o
);
  logic       en_q, phase_q;
  logic [3:0] hi_q;
  logic       rise, fall, wr_take;

  assign rise    = en_i & ~en_q;
  assign fall    = ~en_i & en_q;
  assign wr_take = rise & ~rw_i & ~blocked_i;

  always_comb begin
    wr_vld_o = 1'b0;
    wr_o     = '{rs: rs_i, data: db_i};
    if (wr_take) begin
      if (wide_i) begin
        wr_vld_o = 1'b1;
      end else if (phase_q) begin
        wr_vld_o     = 1'b1;
        wr_o.data    = {hi_q, db_i[7:4]};
      end
    end
  end

  // byte-level read completes on the last falling enable
  assign rd_done_o = fall & rw_i & (wide_i | phase_q);
  assign rd_rs_o   = rs_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      phase_q <= 1'b0;
      hi_q    <= '0;
    end else begin
      en_q <= en_i;
      if (clr_phase_i) begin
        phase_q <= 1'b0;
      end else if (!wide_i) begin
        if (wr_take) begin
          if (!phase_q) hi_q <= db_i[7:4];
          phase_q <= ~phase_q;
        end else if (fall && rw_i) begin
          phase_q <= ~phase_q;
        end
      end
    end
  end

  assign db_oe_o = en_i & rw_i;

  always_comb begin
    if (!db_oe_o)    db_o = '0;
    else if (wide_i) db_o = rd_byte_i;
    else             db_o = {(phase_q ? rd_byte_i[3:0] : rd_byte_i[7:4]), 4'h0};
  end
endmodule

// File: rtl/lcd_busy_timer.sv
module lcd_busy_timer #(
  parameter int unsigned BUSY_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(BUSY_CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (start_i)     cnt_q <= CW'(BUSY_CYC);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/lcd_ram_store.sv
module lcd_ram_store
  import lcd_host_pkg::*;
#(
  parameter int unsigned DD_DEPTH = 80,
  parameter int unsigned CG_DEPTH = 64,
  parameter int unsigned AW       = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  ram_sel_e      wsel_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  ram_sel_e      rsel_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  localparam int unsigned DD_AW = $clog2(DD_DEPTH);
  localparam int unsigned CG_AW = $clog2(CG_DEPTH);

  logic [7:0] dd_mem [DD_DEPTH];
  logic [7:0] cg_mem [CG_DEPTH];

  logic w_dd_ok, w_cg_ok, r_dd_ok, r_cg_ok;
  assign w_dd_ok = waddr_i < AW'(DD_DEPTH);
  assign w_cg_ok = waddr_i < AW'(CG_DEPTH);
  assign r_dd_ok = raddr_i < AW'(DD_DEPTH);
  assign r_cg_ok = raddr_i < AW'(CG_DEPTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DD_DEPTH); i++) dd_mem[i] <= '0;
      for (int i = 0; i < int'(CG_DEPTH); i++) cg_mem[i] <= '0;
    end else if (we_i) begin
      if (wsel_i == RAM_PAT && w_cg_ok)       cg_mem[waddr_i[CG_AW-1:0]] <= wdata_i;
      else if (wsel_i == RAM_DISP && w_dd_ok) dd_mem[waddr_i[DD_AW-1:0]] <= wdata_i;
    end
  end

  always_comb begin
    if (rsel_i == RAM_PAT) rdata_o = r_cg_ok ? cg_mem[raddr_i[CG_AW-1:0]] : 8'h00;
    else                   rdata_o = r_dd_ok ? dd_mem[raddr_i[DD_AW-1:0]] : 8'h00;
  end
endmodule

// File: rtl/lcd_host_if.sv
module lcd_host_if
  import lcd_host_pkg::*;
#(
  parameter int unsigned BUSY_CYC = 8,
  parameter int unsigned DD_DEPTH = 80,
  parameter int unsigned CG_DEPTH = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       rs_i,
  input  logic       rw_i,
  input  logic [7:0] db_i,
  output logic [7:0] db_o,
  output logic       db_oe_o
);
  localparam int unsigned AC_W = $clog2(DD_DEPTH);

  logic            wide_q, busy, wr_vld, rd_done, rd_rs;
  host_xfer_t      wr_x;
  ram_sel_e        sel_q, rsel;
  logic [AC_W-1:0] ac_q, ac_nxt, ac_lim, raddr;
  logic [7:0]      dr_q, rdata, rd_byte;
  logic            set_dd, set_cg, set_fn, dat_wr;

  lcd_bus_phy u_phy (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .rs_i        (rs_i),
    .rw_i        (rw_i),
    .db_i        (db_i),
    .wide_i      (wide_q),
    .clr_phase_i (set_fn),
    .blocked_i   (busy),
    .rd_byte_i   (rd_byte),
    .wr_vld_o    (wr_vld),
    .wr_o        (wr_x),
    .rd_done_o   (rd_done),
    .rd_rs_o     (rd_rs),
    .db_o        (db_o),
    .db_oe_o     (db_oe_o)
  );

  lcd_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_busy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (wr_vld),
    .busy_o  (busy)
  );

  assign set_dd = wr_vld & ~wr_x.rs & wr_x.data[7];
  assign set_cg = wr_vld & ~wr_x.rs & (wr_x.data[7:6] == 2'b01);
  assign set_fn = wr_vld & ~wr_x.rs & (wr_x.data[7:5] == 3'b001);
  assign dat_wr = wr_vld & wr_x.rs;

  assign ac_lim = (sel_q == RAM_PAT) ? AC_W'(CG_DEPTH - 1) : AC_W'(DD_DEPTH - 1);
  assign ac_nxt = (ac_q >= ac_lim) ? '0 : ac_q + 1'b1;

  // single read port: new address on set-address, else next location
  always_comb begin
    if (set_dd) begin
      rsel  = RAM_DISP;
      raddr = AC_W'(wr_x.data[6:0]);
    end else if (set_cg) begin
      rsel  = RAM_PAT;
      raddr = AC_W'(wr_x.data[5:0]);
    end else begin
      rsel  = sel_q;
      raddr = ac_nxt;
    end
  end

  lcd_ram_store #(.DD_DEPTH(DD_DEPTH), .CG_DEPTH(CG_DEPTH), .AW(AC_W)) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (dat_wr),
    .wsel_i  (sel_q),
    .waddr_i (ac_q),
    .wdata_i (wr_x.data),
    .rsel_i  (rsel),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  assign rd_byte = rs_i ? dr_q : {busy, 7'(ac_q)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wide_q <= 1'b1;
      sel_q  <= RAM_DISP;
      ac_q   <= '0;
      dr_q   <= '0;
    end else begin
      if (set_dd || set_cg) begin
        sel_q <= rsel;
        ac_q  <= raddr;
        dr_q  <= rdata;
      end else if (dat_wr) begin
        dr_q <= wr_x.data;
        ac_q <= ac_nxt;
      end else if (rd_done && rd_rs) begin
        ac_q <= ac_nxt;
        dr_q <= rdata;
      end
      if (set_fn) wide_q <= wr_x.data[4];
    end
  end
endmodule

// File: rtl/lcd_host_if_chk.sv
module lcd_host_if_chk #(
  parameter int unsigned DD_DEPTH = 80,
  parameter int unsigned CG_DEPTH = 64,
  parameter int unsigned AC_W     = 7
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            en_i,
  input logic [7:0]      db_o,
  input logic            db_oe_o,
  input logic            wr_vld,
  input logic            wr_rs,
  input logic            busy,
  input logic            sel,
  input logic            wide,
  input logic [AC_W-1:0] ac
);
  // R8
  busy_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_vld |=> busy);

  // R9
  no_write_while_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !wr_vld);

  // R10
  bus_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!db_oe_o && db_o == 8'h00));

  // R6
  narrow_low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wide |-> (db_o[3:0] == 4'h0));

  // R7
  pat_addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel |-> (ac < AC_W'(CG_DEPTH)));

  // R3
  data_write_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_vld && wr_rs && !sel && ac < AC_W'(DD_DEPTH - 1)) |=> (ac == $past(ac) + 1'b1));
endmodule

bind lcd_host_if lcd_host_if_chk #(.DD_DEPTH(DD_DEPTH), .CG_DEPTH(CG_DEPTH), .AC_W(AC_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .db_o    (db_o),
  .db_oe_o (db_oe_o),
  .wr_vld  (wr_vld),
  .wr_rs   (wr_x.rs),
  .busy    (busy),
  .sel     (sel_q),
  .wide    (wide_q),
  .ac      (ac_q)
);

// File: tb/lcd_host_if_bench.sv
module lcd_host_if_bench;
  localparam int CLK_PERIOD = 10;
  localparam int B = 8;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       en_i = 1'b0, rs_i = 1'b0, rw_i = 1'b0;
  logic [7:0] db_i = '0;
  logic [7:0] db_o;
  logic       db_oe_o;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  // behavioural model state
  logic [7:0] dd_m [80];
  logic [7:0] cg_m [64];
  int         m_ac = 0, last_acc = -1000;
  bit         m_sel = 0, m_wide = 1, m_phase = 0;
  logic [3:0] m_hi = '0;
  logic [7:0] m_dr = '0;

  lcd_host_if #(.BUSY_CYC(B)) u_lcd_host_if (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .rs_i(rs_i), .rw_i(rw_i),
    .db_i(db_i), .db_o(db_o), .db_oe_o(db_oe_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(logic [7:0] act, logic [7:0] exp, string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // R10 bus enable compared every clock
  always @(posedge clk_i) begin
    #2;
    if (rst_ni && !done) begin
      checks++;
      if (db_oe_o !== (en_i & rw_i) || (!db_oe_o && db_o !== 8'h00)) begin
        errors++;
        $display("FAIL R10: oe=%0b db=%02h expected oe=%0b", db_oe_o, db_o, en_i & rw_i);
      end
    end
  end

  function automatic logic [7:0] mem_rd(bit s, int a);
    if (s) return (a < 64) ? cg_m[a] : 8'h00;
    return (a < 80) ? dd_m[a] : 8'h00;
  endfunction

  function automatic int nxt_ac();
    int lim = m_sel ? 63 : 79;
    return (m_ac >= lim) ? 0 : m_ac + 1;
  endfunction

  function automatic bit busy_now();
    return (cyc - last_acc) < B;
  endfunction

  task automatic m_exec(bit rs, logic [7:0] b, int e);
    last_acc = e;
    if (rs) begin
      if (m_sel && m_ac < 64) cg_m[m_ac] = b;
      else if (!m_sel && m_ac < 80) dd_m[m_ac] = b;
      m_dr = b;
      m_ac = nxt_ac();
    end else if (b[7]) begin
      m_sel = 0; m_ac = int'(b[6:0]); m_dr = mem_rd(m_sel, m_ac);
    end else if (b[7:6] == 2'b01) begin
      m_sel = 1; m_ac = int'(b[5:0]); m_dr = mem_rd(m_sel, m_ac);
    end else if (b[7:5] == 3'b001) begin
      m_wide = b[4]; m_phase = 0;
    end
  endtask

  task automatic bus_wr(bit rs, logic [7:0] bus);
    int e;
    @(negedge clk_i);
    rs_i = rs; rw_i = 1'b0; db_i = bus; en_i = 1'b1;
    @(negedge clk_i);
    e = cyc; en_i = 1'b0;
    if ((e - last_acc) > B) begin
      if (m_wide) m_exec(rs, bus, e);
      else if (!m_phase) begin m_hi = bus[7:4]; m_phase = 1; end
      else begin m_phase = 0; m_exec(rs, {m_hi, bus[7:4]}, e); end
    end
  endtask

  task automatic wr_byte(bit rs, logic [7:0] b);
    if (m_wide) bus_wr(rs, b);
    else begin
      bus_wr(rs, {b[7:4], 4'h0});
      bus_wr(rs, {b[3:0], 4'h0});
    end
  endtask

  task automatic settle();
    repeat (B + 2) @(negedge clk_i);
  endtask

  task automatic rd_bus(bit rs, string req);
    logic [7:0] full, exp;
    @(negedge clk_i);
    rs_i = rs; rw_i = 1'b1; en_i = 1'b1;
    #1;
    full = rs ? m_dr : {busy_now(), 7'(m_ac)};
    exp  = m_wide ? full : {(m_phase ? full[3:0] : full[7:4]), 4'h0};
    check(db_o, exp, req);
    @(negedge clk_i);
    en_i = 1'b0;
    @(negedge clk_i);
    if (m_wide || m_phase) begin
      m_phase = 0;
      if (rs) begin m_ac = nxt_ac(); m_dr = mem_rd(m_sel, m_ac); end
    end else m_phase = 1;
    rw_i = 1'b0;
  endtask

  task automatic rd_byte(bit rs, string req);
    if (m_wide) rd_bus(rs, req);
    else begin rd_bus(rs, req); rd_bus(rs, req); end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 80; i++) dd_m[i] = '0;
    for (int i = 0; i < 64; i++) cg_m[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    rd_byte(0, "R1 reset status");

    wr_byte(0, 8'h86);
    rd_byte(0, "R8 busy after instruction");
    wr_byte(1, 8'h41);                      // R9: lands inside busy window
    settle();
    rd_byte(0, "R9 ignored write, R2 status not instruction");

    wr_byte(1, 8'h41); settle();
    wr_byte(1, 8'h42); settle();
    rd_byte(0, "R3 address advanced by data writes");

    wr_byte(0, 8'h86); settle();
    rd_byte(1, "R5 prefetch on set address");
    rd_byte(1, "R4 read prefetch");
    rd_byte(0, "R4 address after reads");

    wr_byte(0, 8'hCF); settle();
    wr_byte(1, 8'h7E); settle();
    rd_byte(0, "R7 display wrap on write");
    wr_byte(0, 8'hCF); settle();
    rd_byte(1, "R4 read at top of display");
    rd_byte(0, "R7 display wrap on read");

    wr_byte(0, 8'h7F); settle();
    wr_byte(1, 8'h1F); settle();
    rd_byte(0, "R7 pattern wrap on write");
    wr_byte(0, 8'h40); settle();
    wr_byte(1, 8'h0A); settle();
    wr_byte(0, 8'h7F); settle();
    rd_byte(1, "R5 pattern address read");
    rd_byte(1, "R7 pattern wrap prefetch");
    wr_byte(0, 8'h80); settle();
    rd_byte(1, "R5 display memory separate from pattern");

    wr_byte(0, 8'h20); settle();
    wr_byte(0, 8'h90); settle();
    wr_byte(1, 8'h5A); settle();
    wr_byte(0, 8'h90); settle();
    rd_byte(1, "R6 nibble data read");
    rd_byte(0, "R6 nibble status read");
    wr_byte(0, 8'h93); settle();
    rd_byte(0, "R6 nibble instruction");
    wr_byte(0, 8'h30); settle();
    rd_byte(0, "R6 back to 8-bit");

    repeat (3) @(negedge clk_i);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule